// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Interlock

This block is the hazard unit for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Conditional branches in this pipeline are decided by an equality comparator that sits in the decode stage. No bypass path reaches that comparator from any later stage. The only bypass paths feed the ALU inputs in the execute stage.

When a branch in decode reads a register that a later-stage instruction has yet to write, the block freezes the program counter and the fetch/decode register. In the same cycle it turns the decode/execute register into a bubble. The branch is released only once its producer has fully retired. A producer directly ahead of the branch costs three bubbles, a producer two ahead costs two, and a producer three ahead costs one.

The block also produces the usual execute-stage ALU operand forwarding selects for non-branch instructions. Non-branch instructions are never interlocked here. A free-running counter reports how many stall cycles have been inserted since reset. The hazard and forwarding outputs are purely combinational. The only state is the stall counter.

Top module: `branch_interlock`

## Requirements
- R1: While a valid branch is in decode, `hold_fetch` and `bubble_exe` are 1 in the same cycle if either branch source register equals the destination of an execute-stage instruction that is valid and writes a register.
- R2: The same stall occurs when the matching valid, register-writing instruction is in the memory stage. There is no bypass from memory to decode.
- R3: The same stall occurs when the matching valid, register-writing instruction is in the writeback stage. There is no write-then-read through the register file in the same cycle.
- R4: Register 0 never causes a stall, whether it is a branch source or a producer destination.
- R5: A later-stage entry whose valid bit or write-enable bit is 0 never causes a stall and is never forwarded from.
- R6: An instruction in decode that is not a branch, or a decode slot that is not valid, never causes a stall.
- R7: `hold_fetch` and `bubble_exe` always have equal values.
- R8: Each ALU operand select is encoded as 2'b10 for the memory-stage result, 2'b01 for the writeback result and 2'b00 for the register file. When both later stages match, the memory stage wins. The value 2'b11 is never produced.
- R9: An execute-stage source of register 0 always selects the register file (2'b00).
- R10: `stall_count` is 0 after reset. It rises by exactly one on each clock edge where a stall is asserted, holds otherwise, and saturates at all ones.
- R11: When the pipeline advances normally around the stall, a producer one, two or three instructions ahead of a branch results in 3, 2 or 1 stall cycles respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decode slot holds a real instruction |
| dec_is_branch | input | 1 | Decode instruction is a conditional branch |
| dec_rs1 | input | REG_AW | Decode first source register |
| dec_rs2 | input | REG_AW | Decode second source register |
| exe_valid | input | 1 | Execute slot valid |
| exe_wen | input | 1 | Execute instruction writes a register |
| exe_rd | input | REG_AW | Execute destination register |
| exe_rs1 | input | REG_AW | Execute first ALU source |
| exe_rs2 | input | REG_AW | Execute second ALU source |
| mem_valid | input | 1 | Memory slot valid |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_rd | input | REG_AW | Memory destination register |
| wb_valid | input | 1 | Writeback slot valid |
| wb_wen | input | 1 | Writeback instruction writes a register |
| wb_rd | input | REG_AW | Writeback destination register |
| hold_fetch | output | 1 | Freeze PC and fetch/decode register |
| bubble_exe | output | 1 | Load a NOP into the decode/execute register |
| fwd_a_sel | output | 2 | First ALU operand source select |
| fwd_b_sel | output | 2 | Second ALU operand source select |
| stall_count | output | CNT_W | Saturating count of stall cycles since reset |

## Verification
The checker evaluates the following on every cycle:
- Stalls occur in each of the three producer stages.
- A non-branch instruction or a zero source register never stalls.
- The hold and bubble outputs always agree.
- The forwarding select never takes the unused code, and the memory stage wins whenever it matches.
- The stall counter steps, holds and saturates correctly.

The bench scenarios are needed to show the bubble counts of R11. They require a moving pipeline model in which the producer advances while the branch stays held. The scenarios also cover the ignored-entry cases of R5 and the exact counter value after a long saturating stall.

// File: rtl/bil_pkg.sv
package bil_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    localparam int unsigned PROD_STAGES = 3;
endpackage

// File: rtl/bil_stage_match.sv
module bil_stage_match #(
    parameter int unsigned REG_AW  = 5,
    parameter int unsigned NSTAGES = 3
) (
    input  logic [NSTAGES-1:0]             st_valid,
    input  logic [NSTAGES-1:0]             st_wen,
    input  logic [NSTAGES-1:0][REG_AW-1:0] st_rd,
    input  logic [REG_AW-1:0]              src_a,
    input  logic [REG_AW-1:0]              src_b,
    output logic                           any_hit
);
    logic [NSTAGES-1:0] hit_vec;

    for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
        logic writes_real;
        assign writes_real = st_valid[s] && st_wen[s] && (st_rd[s] != '0);
        assign hit_vec[s]  = writes_real && ((st_rd[s] == src_a) || (st_rd[s] == src_b));
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/bil_fwd_select.sv
module bil_fwd_select
    import bil_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              mem_valid,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              wb_valid,
    input  logic              wb_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic [REG_AW-1:0] src,
    output fwd_sel_e          sel
);
    logic mem_match, wb_match;

    always_comb begin
        mem_match = mem_valid && mem_wen && (src != '0) && (mem_rd == src);
        wb_match  = wb_valid  && wb_wen  && (src != '0) && (wb_rd  == src);
        if (mem_match)     sel = FWD_MEM;
        else if (wb_match) sel = FWD_WB;
        else               sel = FWD_RF;
    end
endmodule

// File: rtl/bil_stall_counter.sv
module bil_stall_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       count <= '0;
        else if (inc && count != CNT_MAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/branch_interlock.sv
module branch_interlock
    import bil_pkg::*;
#(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic              dec_is_branch,
    input  logic [REG_AW-1:0] dec_rs1,
    input  logic [REG_AW-1:0] dec_rs2,
    input  logic              exe_valid,
    input  logic              exe_wen,
    input  logic [REG_AW-1:0] exe_rd,
    input  logic [REG_AW-1:0] exe_rs1,
    input  logic [REG_AW-1:0] exe_rs2,
    input  logic              mem_valid,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              wb_valid,
    input  logic              wb_wen,
    input  logic [REG_AW-1:0] wb_rd,
    output logic              hold_fetch,
    output logic              bubble_exe,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic [CNT_W-1:0]  stall_count
);
    localparam int unsigned NS = PROD_STAGES;

    logic [NS-1:0]             p_valid, p_wen;
    logic [NS-1:0][REG_AW-1:0] p_rd;
    logic                      src_busy;
    logic                      stall;

    assign p_valid = {wb_valid, mem_valid, exe_valid};
    assign p_wen   = {wb_wen, mem_wen, exe_wen};
    assign p_rd    = {wb_rd, mem_rd, exe_rd};

    bil_stage_match #(.REG_AW(REG_AW), .NSTAGES(NS)) u_match (
        .st_valid (p_valid),
        .st_wen   (p_wen),
        .st_rd    (p_rd),
        .src_a    (dec_rs1),
        .src_b    (dec_rs2),
        .any_hit  (src_busy)
    );

    assign stall      = dec_valid && dec_is_branch && src_busy;
    assign hold_fetch = stall;
    assign bubble_exe = stall;

    logic [1:0][REG_AW-1:0] exe_src;
    fwd_sel_e [1:0]         op_sel;
    assign exe_src = {exe_rs2, exe_rs1};

    for (genvar k = 0; k < 2; k++) begin : g_op
        bil_fwd_select #(.REG_AW(REG_AW)) u_fwd (
            .mem_valid (mem_valid),
            .mem_wen   (mem_wen),
            .mem_rd    (mem_rd),
            .wb_valid  (wb_valid),
            .wb_wen    (wb_wen),
            .wb_rd     (wb_rd),
            .src       (exe_src[k]),
            .sel       (op_sel[k])
        );
    end

    assign fwd_a_sel = op_sel[0];
    assign fwd_b_sel = op_sel[1];

    bil_stall_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (stall),
        .count (stall_count)
    );
endmodule

// File: rtl/bil_checker.sv
module bil_checker #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic              dec_is_branch,
    input logic [REG_AW-1:0] dec_rs1,
    input logic [REG_AW-1:0] dec_rs2,
    input logic              exe_valid,
    input logic              exe_wen,
    input logic [REG_AW-1:0] exe_rd,
    input logic [REG_AW-1:0] exe_rs1,
    input logic              mem_valid,
    input logic              mem_wen,
    input logic [REG_AW-1:0] mem_rd,
    input logic              wb_valid,
    input logic              wb_wen,
    input logic [REG_AW-1:0] wb_rd,
    input logic              hold_fetch,
    input logic              bubble_exe,
    input logic [1:0]        fwd_a_sel,
    input logic [1:0]        fwd_b_sel,
    input logic [CNT_W-1:0]  stall_count
);
    logic br_dec;
    assign br_dec = dec_valid && dec_is_branch;

    p_exe_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (br_dec && exe_valid && exe_wen && exe_rd != '0 && (exe_rd == dec_rs1 || exe_rd == dec_rs2)) |-> hold_fetch);

    p_mem_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_dec && mem_valid && mem_wen && mem_rd != '0 && (mem_rd == dec_rs1 || mem_rd == dec_rs2)) |-> hold_fetch);

    p_wb_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_dec && wb_valid && wb_wen && wb_rd != '0 && (wb_rd == dec_rs1 || wb_rd == dec_rs2)) |-> hold_fetch);

    p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_rs1 == '0 && dec_rs2 == '0) |-> !hold_fetch);

    p_nonbranch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !br_dec |-> !hold_fetch);

    p_hold_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_fetch == bubble_exe);

    p_sel_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11);

    p_mem_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_wen && exe_rs1 != '0 && mem_rd == exe_rs1) |-> fwd_a_sel == 2'b10);

    p_zero_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exe_rs1 == '0 |-> fwd_a_sel == 2'b00);

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_fetch && stall_count != '1) |=> stall_count == $past(stall_count) + 1'b1);

    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_fetch |=> $stable(stall_count));

    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_count == '1 |=> stall_count == '1);
endmodule

bind branch_interlock bil_checker #(.REG_AW(REG_AW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_branch(dec_is_branch),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .exe_valid(exe_valid), .exe_wen(exe_wen),
    .exe_rd(exe_rd), .exe_rs1(exe_rs1), .mem_valid(mem_valid), .mem_wen(mem_wen),
    .mem_rd(mem_rd), .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd),
    .hold_fetch(hold_fetch), .bubble_exe(bubble_exe), .fwd_a_sel(fwd_a_sel),
    .fwd_b_sel(fwd_b_sel), .stall_count(stall_count)
);

// File: tb/branch_interlock_test.sv
module branch_interlock_test;
    localparam int AW = 5;
    localparam int CW = 6;
    localparam int NV = 12;
    localparam int VW = 47;

    // {br, rs1, rs2, ev, ew, erd, mv, mw, mrd, wv, ww, wrd, ers1, ers2, exp_stall, exp_a, exp_b}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 5'd5, 5'd6, 1'b1, 1'b1, 5'd5,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  5'd0, 5'd0, 1'b1, 2'b00, 2'b00}, // R1
        {1'b1, 5'd5, 5'd6, 1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 5'd6,  1'b0, 1'b0, 5'd0,  5'd0, 5'd0, 1'b1, 2'b00, 2'b00}, // R2
        {1'b1, 5'd5, 5'd6, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 5'd5,  5'd0, 5'd0, 1'b1, 2'b00, 2'b00}, // R3
        {1'b1, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0,  1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  5'd0, 5'd0, 1'b0, 2'b00, 2'b00}, // R4
        {1'b1, 5'd5, 5'd6, 1'b1, 1'b0, 5'd5,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  5'd0, 5'd0, 1'b0, 2'b00, 2'b00}, // R5
        {1'b1, 5'd5, 5'd6, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1, 5'd6,  1'b0, 1'b1, 5'd5,  5'd0, 5'd0, 1'b0, 2'b00, 2'b00}, // R5
        {1'b0, 5'd5, 5'd6, 1'b1, 1'b1, 5'd5,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  5'd0, 5'd0, 1'b0, 2'b00, 2'b00}, // R6
        {1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 5'd7,  1'b1, 1'b1, 5'd7,  5'd7, 5'd8, 1'b0, 2'b10, 2'b00}, // R8
        {1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 5'd3,  1'b1, 1'b1, 5'd8,  5'd3, 5'd8, 1'b0, 2'b10, 2'b01}, // R8
        {1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b1, 5'd0,  5'd0, 5'd0, 1'b0, 2'b00, 2'b00}, // R9
        {1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 5'd9,  1'b1, 1'b1, 5'd9,  5'd9, 5'd9, 1'b0, 2'b01, 2'b01}, // R5 R8
        {1'b1, 5'd7, 5'd8, 1'b1, 1'b1, 5'd9,  1'b1, 1'b1, 5'd10, 1'b1, 1'b1, 5'd11, 5'd0, 5'd0, 1'b0, 2'b00, 2'b00}  // R1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0, dec_is_branch = 1'b0;
    logic [AW-1:0] dec_rs1 = '0, dec_rs2 = '0;
    logic exe_valid = 1'b0, exe_wen = 1'b0;
    logic [AW-1:0] exe_rd = '0, exe_rs1 = '0, exe_rs2 = '0;
    logic mem_valid = 1'b0, mem_wen = 1'b0;
    logic [AW-1:0] mem_rd = '0;
    logic wb_valid = 1'b0, wb_wen = 1'b0;
    logic [AW-1:0] wb_rd = '0;
    logic hold_fetch, bubble_exe;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic [CW-1:0] stall_count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    branch_interlock #(.REG_AW(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_branch(dec_is_branch),
        .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .exe_valid(exe_valid), .exe_wen(exe_wen),
        .exe_rd(exe_rd), .exe_rs1(exe_rs1), .exe_rs2(exe_rs2), .mem_valid(mem_valid),
        .mem_wen(mem_wen), .mem_rd(mem_rd), .wb_valid(wb_valid), .wb_wen(wb_wen),
        .wb_rd(wb_rd), .hold_fetch(hold_fetch), .bubble_exe(bubble_exe),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .stall_count(stall_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stages();
        dec_valid = 1'b0; dec_is_branch = 1'b0; dec_rs1 = '0; dec_rs2 = '0;
        exe_valid = 1'b0; exe_wen = 1'b0; exe_rd = '0; exe_rs1 = '0; exe_rs2 = '0;
        mem_valid = 1'b0; mem_wen = 1'b0; mem_rd = '0;
        wb_valid = 1'b0; wb_wen = 1'b0; wb_rd = '0;
    endtask

    // Producer of r5 starts 'pos' stages ahead (0 = EXE); the branch stays held in DEC.
    task automatic run_seq(input int pos, input int exp_cycles, input string req);
        logic [2:0] at;
        int n;
        logic [CW-1:0] c0;
        at = 3'b001 << pos;
        n = 0;
        @(negedge clk);
        c0 = stall_count;
        for (int cyc = 0; cyc < 8; cyc++) begin
            dec_valid = 1'b1; dec_is_branch = 1'b1; dec_rs1 = 5'd5; dec_rs2 = 5'd1;
            exe_valid = 1'b1; exe_wen = at[0]; exe_rd = at[0] ? 5'd5 : 5'd0;
            mem_valid = 1'b1; mem_wen = at[1]; mem_rd = at[1] ? 5'd5 : 5'd0;
            wb_valid  = 1'b1; wb_wen  = at[2]; wb_rd  = at[2] ? 5'd5 : 5'd0;
            #1;
            if (!hold_fetch) break;
            n++;
            @(negedge clk);
            at = {at[1:0], 1'b0};
        end
        check(req, n, exp_cycles);
        check("R10 delta", int'(stall_count - c0), exp_cycles);
        clear_stages();
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset count", int'(stall_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            dec_valid = 1'b1;
            {dec_is_branch, dec_rs1, dec_rs2, exe_valid, exe_wen, exe_rd,
             mem_valid, mem_wen, mem_rd, wb_valid, wb_wen, wb_rd, exe_rs1, exe_rs2} = v[VW-1:5];
            #1;
            check($sformatf("R1-table vec%0d stall", i), int'(hold_fetch), int'(v[4]));
            check($sformatf("R7 vec%0d bubble", i), int'(bubble_exe), int'(v[4]));
            check($sformatf("R8 vec%0d sel_a", i), int'(fwd_a_sel), int'(v[3:2]));
            check($sformatf("R8 vec%0d sel_b", i), int'(fwd_b_sel), int'(v[1:0]));
            @(negedge clk);
        end
        clear_stages();
        @(negedge clk);
        // table stalled in vectors 0,1,2: three cycles counted
        check("R10 count after table", int'(stall_count), 3);

        dec_valid = 1'b0; dec_is_branch = 1'b1; dec_rs1 = 5'd5;
        exe_valid = 1'b1; exe_wen = 1'b1; exe_rd = 5'd5;
        #1;
        check("R6 invalid dec slot", int'(hold_fetch), 0);
        clear_stages();

        run_seq(0, 3, "R11 adjacent");
        run_seq(1, 2, "R11 gap one");
        run_seq(2, 1, "R11 gap two");
        check("R10 count after seq", int'(stall_count), 9);

        @(negedge clk);
        dec_valid = 1'b1; dec_is_branch = 1'b1; dec_rs2 = 5'd4;
        wb_valid = 1'b1; wb_wen = 1'b1; wb_rd = 5'd4;
        repeat (80) @(negedge clk);
        check("R10 saturate", int'(stall_count), 63);
        clear_stages();
        @(negedge clk);
        check("R10 holds when idle", int'(stall_count), 63);

        rst_n = 1'b0;
        #1;
        check("R10 async reset", int'(stall_count), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule